// File: doc/BRIEF.md
# NAND Boot Copy and Address-Zero Remap Controller

When reset ends, this block keeps the processor in reset. It then reads the start of a raw NAND device into an on-chip SRAM. The processor can only fetch code from memory that sits on its bus, and the NAND array is never on that bus. The block reads the device one page at a time. For each page it sends a command byte, the address bytes and a confirm byte. It then waits for the device's ready/busy line to go busy and come back, and strobes out the page one byte at a time. Each byte is written to the next SRAM location. After eight pages of 512 bytes, the 4 KB SRAM holds the boot image and the processor reset is released.

A boot strap chooses between two modes. The strap is sampled in the first cycle after reset ends.

- **NAND boot:** the low bank of the processor address space, which holds address zero, selects the internal SRAM.
- **Any other strap value:** the copy is skipped, the processor is released at once, and the low bank drives the external bank-0 chip select.

The controller watches how long each ready/busy wait lasts. If a wait runs past a limit set on an input, the controller gives up. It raises a sticky error and keeps the processor in reset.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset ends with `boot_nand`=1, `cpu_rst_n` stays 0 and `boot_done` stays 0 until the last image byte has been written. While `rst_n` is 0, `cpu_rst_n`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0 and `nand_ale`=0.
- R2: Each page read is a fixed series of bytes, each latched on a rising edge of `nand_we_n`:
  - 0x00 with `nand_cle`=1;
  - five bytes with `nand_ale`=1: two zero column bytes, then the page number over three row bytes, least significant first;
  - 0x30 with `nand_cle`=1.
  Pages are read in order 0 to 7.
- R3: After the 0x30 byte, `nand_re_n` does not go low until `nand_rb_n` has been seen low and then high again. `nand_re_n` is never low while `nand_rb_n` is low.
- R4: Each page gives 512 `nand_re_n` low pulses. Each pulse makes one `sram_we` pulse that carries the byte on `nand_io_in` while `nand_re_n` was low. The address starts at 0 and rises by one per write, for exactly 4096 writes.
- R5: Once the last write is done, `boot_done`=1 and `cpu_rst_n`=1, and both stay there.
- R6: With `boot_nand`=0 at reset release, `cpu_rst_n` and `boot_done` are 1 within two clock cycles. No NAND strobe and no SRAM write occurs.
- R7: If `nand_rb_n` stays in either awaited level for more than `rb_timeout_limit` cycles, `boot_timeout` becomes 1 and stays 1. `cpu_rst_n` stays 0 and no further NAND strobe occurs.
- R8: With NAND boot latched, a `cpu_addr` whose bits [31:27] are all zero gives `cpu_sel_sram`=1 and `cpu_sel_bank0_n`=1. The 4 KB SRAM repeats across that bank.
- R9: With NAND boot not latched, a `cpu_addr` with bits [31:27] zero gives `cpu_sel_bank0_n`=0 and `cpu_sel_sram`=0. Any other address gives `cpu_sel_sram`=0 and `cpu_sel_bank0_n`=1 in both modes. The two selects are never active together.
- R10: `nand_cle` and `nand_ale` are never 1 at the same time. `nand_io_oe` is 1 only during command and address bytes.
- R11: The decode follows the strap value latched at reset release. Changing `boot_nand` later has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_nand | input | 1 | Boot strap; 1 selects NAND boot |
| rb_timeout_limit | input | 16 | Longest allowed wait on ready/busy, in cycles |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_rb_n | input | 1 | NAND ready (1) / busy (0) |
| nand_io_in | input | 8 | NAND data in |
| nand_io_out | output | 8 | NAND command/address byte out |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 12 | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| cpu_addr | input | 32 | Processor address |
| cpu_sel_sram | output | 1 | Internal SRAM selected |
| cpu_sel_bank0_n | output | 1 | External bank-0 chip select, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| boot_done | output | 1 | Copy finished or skipped |
| boot_timeout | output | 1 | Ready/busy wait timed out |

## Verification
The hardest case to reach is the ready/busy timeout. A device model that always answers promptly never stalls the copy. The bench therefore uses its own NAND model with a busy time it can set. It runs one full copy with a short busy time and a large limit, and a second run where the busy time is well past the limit. The same model flags any read strobe that starts before busy has ended.

// File: rtl/nboot_pkg.sv
package nboot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD_RD, ST_ADDR, ST_CMD_GO,
    ST_WAIT_LO, ST_WAIT_HI, ST_READ, ST_DONE, ST_FAIL
  } seq_state_t;

  localparam logic [7:0] CMD_READ_SETUP = 8'h00;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam int         ADDR_CYCLES    = 5;

  // Byte sent in address cycle idx: two zero column bytes, then row LSB first.
  function automatic logic [7:0] addr_byte(input logic [23:0] row, input logic [2:0] idx);
    case (idx)
      3'd2:    return row[7:0];
      3'd3:    return row[15:8];
      3'd4:    return row[23:16];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nboot_addr_decode.sv
module nboot_addr_decode #(
  parameter int BANK_SHIFT = 27
) (
  input  logic [31:0] cpu_addr,
  input  logic        nand_mode,
  output logic        cpu_sel_sram,
  output logic        cpu_sel_bank0_n
);
  logic low_bank;
  assign low_bank        = (cpu_addr >> BANK_SHIFT) == 32'd0;
  assign cpu_sel_sram    = low_bank && nand_mode;
  assign cpu_sel_bank0_n = !(low_bank && !nand_mode);
endmodule

// File: rtl/nboot_seq.sv
module nboot_seq
  import nboot_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int NUM_PAGES  = 8,
  parameter int TO_W       = 16,
  parameter int SRAM_AW    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_nand,
  input  logic [TO_W-1:0]    rb_timeout_limit,
  input  logic               nand_rb_n,
  input  logic [7:0]         nand_io_in,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_io_out,
  output logic               nand_io_oe,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               nand_mode,
  output logic               copy_done,
  output logic               copy_fail
);
  localparam int BYTE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  seq_state_t          state;
  logic                ph;
  logic [2:0]          aidx;
  logic [PG_W-1:0]     page;
  logic [BYTE_W-1:0]   bcnt;
  logic [SRAM_AW-1:0]  wptr;
  logic [TO_W-1:0]     wcnt;

  // Named internal events
  logic step_end, byte_last, page_last, to_hit, addr_last;
  assign step_end  = ph;
  assign byte_last = bcnt == BYTE_W'(PAGE_BYTES - 1);
  assign page_last = page == PG_W'(NUM_PAGES - 1);
  assign to_hit    = wcnt >= rb_timeout_limit;
  assign addr_last = aidx == 3'(ADDR_CYCLES - 1);

  assign nand_cle    = (state == ST_CMD_RD) || (state == ST_CMD_GO);
  assign nand_ale    = (state == ST_ADDR);
  assign nand_io_oe  = nand_cle || nand_ale;
  assign nand_we_n   = !(nand_io_oe && !ph);
  assign nand_re_n   = !((state == ST_READ) && !ph);
  assign nand_io_out = (state == ST_CMD_RD) ? CMD_READ_SETUP :
                       (state == ST_CMD_GO) ? CMD_READ_GO :
                       addr_byte(24'(page), aidx);
  assign copy_done   = (state == ST_DONE);
  assign copy_fail   = (state == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ph         <= 1'b0;
      aidx       <= '0;
      page       <= '0;
      bcnt       <= '0;
      wptr       <= '0;
      wcnt       <= '0;
      nand_mode  <= 1'b0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      sram_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          nand_mode <= boot_nand;
          state     <= boot_nand ? ST_CMD_RD : ST_DONE;
          ph        <= 1'b0;
        end
        ST_CMD_RD: begin
          ph <= ~ph;
          if (step_end) begin
            state <= ST_ADDR;
            aidx  <= '0;
          end
        end
        ST_ADDR: begin
          ph <= ~ph;
          if (step_end) begin
            if (addr_last) state <= ST_CMD_GO;
            else           aidx  <= aidx + 3'd1;
          end
        end
        ST_CMD_GO: begin
          ph <= ~ph;
          if (step_end) begin
            state <= ST_WAIT_LO;
            wcnt  <= '0;
          end
        end
        ST_WAIT_LO: begin
          if (!nand_rb_n) begin
            state <= ST_WAIT_HI;
            wcnt  <= '0;
          end else if (to_hit) state <= ST_FAIL;
          else                 wcnt  <= wcnt + 1'b1;
        end
        ST_WAIT_HI: begin
          if (nand_rb_n) begin
            state <= ST_READ;
            ph    <= 1'b0;
            bcnt  <= '0;
          end else if (to_hit) state <= ST_FAIL;
          else                 wcnt  <= wcnt + 1'b1;
        end
        ST_READ: begin
          ph <= ~ph;
          if (!step_end) begin
            sram_we    <= 1'b1;
            sram_wdata <= nand_io_in;
            sram_addr  <= wptr;
            wptr       <= wptr + 1'b1;
          end else if (byte_last) begin
            if (page_last) state <= ST_DONE;
            else begin
              page  <= page + 1'b1;
              state <= ST_CMD_RD;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader #(
  parameter  int PAGE_BYTES = 512,
  parameter  int NUM_PAGES  = 8,
  parameter  int TO_W       = 16,
  parameter  int BANK_SHIFT = 27,
  localparam int SRAM_AW    = $clog2(PAGE_BYTES * NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_nand,
  input  logic [TO_W-1:0]    rb_timeout_limit,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  input  logic               nand_rb_n,
  input  logic [7:0]         nand_io_in,
  output logic [7:0]         nand_io_out,
  output logic               nand_io_oe,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  input  logic [31:0]        cpu_addr,
  output logic               cpu_sel_sram,
  output logic               cpu_sel_bank0_n,
  output logic               cpu_rst_n,
  output logic               boot_done,
  output logic               boot_timeout
);
  logic nand_mode, copy_done, copy_fail;

  nboot_seq #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .TO_W(TO_W), .SRAM_AW(SRAM_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .boot_nand(boot_nand),
    .rb_timeout_limit(rb_timeout_limit), .nand_rb_n(nand_rb_n),
    .nand_io_in(nand_io_in), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .nand_mode(nand_mode),
    .copy_done(copy_done), .copy_fail(copy_fail)
  );

  nboot_addr_decode #(.BANK_SHIFT(BANK_SHIFT)) u_dec (
    .cpu_addr(cpu_addr), .nand_mode(nand_mode),
    .cpu_sel_sram(cpu_sel_sram), .cpu_sel_bank0_n(cpu_sel_bank0_n)
  );

  assign cpu_rst_n    = copy_done;
  assign boot_done    = copy_done;
  assign boot_timeout = copy_fail;
endmodule

// File: rtl/nand_boot_loader_chk.sv
module nand_boot_loader_chk #(
  parameter int SRAM_AW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boot_nand,
  input logic               nand_cle,
  input logic               nand_ale,
  input logic               nand_we_n,
  input logic               nand_re_n,
  input logic               nand_rb_n,
  input logic               sram_we,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               cpu_sel_sram,
  input logic               cpu_sel_bank0_n,
  input logic               cpu_rst_n,
  input logic               boot_timeout
);
  logic               seen_wr;
  logic [SRAM_AW-1:0] last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0;
      last_wr <= '0;
    end else if (sram_we) begin
      seen_wr <= 1'b1;
      last_wr <= sram_addr;
    end
  end

  // R1
  wr_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> !cpu_rst_n);
  // R3
  re_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> nand_rb_n);
  // R4
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && !seen_wr) |-> sram_addr == '0);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && seen_wr) |-> sram_addr == last_wr + 1'b1);
  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_nand |-> (nand_we_n && nand_re_n && !sram_we));
  // R7
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_timeout |=> (boot_timeout && !cpu_rst_n));
  // R9
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel_sram && !cpu_sel_bank0_n));
  // R10
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
endmodule

bind nand_boot_loader nand_boot_loader_chk #(.SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_nand(boot_nand),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n), .sram_we(sram_we),
  .sram_addr(sram_addr), .cpu_sel_sram(cpu_sel_sram),
  .cpu_sel_bank0_n(cpu_sel_bank0_n), .cpu_rst_n(cpu_rst_n),
  .boot_timeout(boot_timeout)
);

// File: tb/nand_boot_loader_bench.sv
`timescale 1ns/1ps
module nand_boot_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_nand = 1'b1;
  logic [15:0] rb_timeout_limit = 16'd1000;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_rb_n, nand_io_oe;
  logic [7:0]  nand_io_in, nand_io_out, sram_wdata;
  logic        sram_we, cpu_sel_sram, cpu_sel_bank0_n, cpu_rst_n, boot_done, boot_timeout;
  logic [11:0] sram_addr;
  logic [31:0] cpu_addr = 32'd0;

  always #5 clk = ~clk;

  nand_boot_loader u_nand_boot_loader (.*);

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- NAND and SRAM model ----------------
  int          busy_len = 30;
  logic [7:0]  mem [4096];
  int          wr_cnt, addr_err, seq_err, re_err, strobe_cnt, re_cnt, pages_go;
  int          pos, col, busy_left;
  logic [7:0]  cur_row;
  logic        we_q, re_q, data_ok;

  function automatic logic [7:0] img(input int row, input int c);
    return 8'((row * 37) + (c * 3) + (c >> 8));
  endfunction

  assign nand_io_in = img(int'(cur_row), col);
  assign nand_rb_n  = !(busy_left > 0 && busy_left <= busy_len);

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_cnt = 0; addr_err = 0; seq_err = 0; re_err = 0; strobe_cnt = 0;
      re_cnt = 0; pages_go = 0; pos = 0; col = 0; busy_left = 0;
      cur_row = 8'd0; we_q = 1'b1; re_q = 1'b1; data_ok = 1'b0;
    end else begin
      if (busy_left > 0) busy_left = busy_left - 1;
      if (nand_we_n && !we_q) begin
        strobe_cnt++;
        case (pos)
          0: if (!(nand_cle && !nand_ale && nand_io_out == 8'h00)) seq_err++;
          6: if (!(nand_cle && !nand_ale && nand_io_out == 8'h30)) seq_err++;
          3: begin
            if (!(nand_ale && !nand_cle && nand_io_out == 8'(pages_go))) seq_err++;
            cur_row = nand_io_out;
          end
          default: if (!(nand_ale && !nand_cle && nand_io_out == 8'h00)) seq_err++;
        endcase
        if (pos == 6) begin
          pos = 0; pages_go++; col = 0; busy_left = busy_len + 2; data_ok = 1'b0;
        end else pos++;
      end
      if (busy_left == 0 && pages_go > 0) data_ok = 1'b1;
      if (!nand_re_n && re_q) begin
        re_cnt++;
        if (!data_ok || !nand_rb_n) re_err++;
      end
      if (nand_re_n && !re_q) col++;
      if (sram_we) begin
        if (sram_addr != 12'(wr_cnt)) addr_err++;
        mem[sram_addr] = sram_wdata;
        wr_cnt++;
      end
      we_q = nand_we_n;
      re_q = nand_re_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset(input logic strap, input int busy, input logic [15:0] lim);
    @(negedge clk);
    rst_n = 1'b0;
    boot_nand = strap;
    busy_len = busy;
    rb_timeout_limit = lim;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Decode vectors: {strap, addr, exp_sel_sram, exp_sel_bank0_n}
  localparam int NVEC = 8;
  localparam logic [34:0] DEC_VEC [NVEC] = '{
    {1'b1, 32'h0000_0000, 1'b1, 1'b1},
    {1'b1, 32'h0000_0FFC, 1'b1, 1'b1},
    {1'b1, 32'h07FF_FFFF, 1'b1, 1'b1},
    {1'b1, 32'h0800_0000, 1'b0, 1'b1},
    {1'b0, 32'h0000_0000, 1'b0, 1'b0},
    {1'b0, 32'h0000_0FFC, 1'b0, 1'b0},
    {1'b0, 32'h07FF_FFFF, 1'b0, 1'b0},
    {1'b0, 32'h3000_0000, 1'b0, 1'b1}
  };

  task automatic walk_decode(input logic strap);
    for (int i = 0; i < NVEC; i++) begin
      if (DEC_VEC[i][34] == strap) begin
        cpu_addr = DEC_VEC[i][33:2];
        #1;
        check(strap ? "R8 sel_sram" : "R9 sel_sram", 32'(cpu_sel_sram), 32'(DEC_VEC[i][1]));
        check(strap ? "R8 sel_bank0_n" : "R9 sel_bank0_n", 32'(cpu_sel_bank0_n), 32'(DEC_VEC[i][0]));
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int bad;
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 cpu_rst_n in reset", 32'(cpu_rst_n), 0);
    check("R1 we_n in reset", 32'(nand_we_n), 1);
    check("R1 re_n in reset", 32'(nand_re_n), 1);
    check("R1 cle/ale in reset", 32'({nand_cle, nand_ale}), 0);

    // Full NAND boot
    do_reset(1'b1, 30, 16'd1000);
    repeat (1000) @(negedge clk);
    check("R1 cpu held mid-copy", 32'(cpu_rst_n), 0);
    check("R1 done low mid-copy", 32'(boot_done), 0);
    for (int k = 0; k < 40000 && !boot_done; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R5 boot_done", 32'(boot_done), 1);
    check("R5 cpu_rst_n released", 32'(cpu_rst_n), 1);
    check("R2 command/address sequence errors", 32'(seq_err), 0);
    check("R2 pages requested", 32'(pages_go), 8);
    check("R3 early read strobes", 32'(re_err), 0);
    check("R4 read strobes", 32'(re_cnt), 4096);
    check("R4 sram writes", 32'(wr_cnt), 4096);
    check("R4 sram address order", 32'(addr_err), 0);
    bad = 0;
    for (int a = 0; a < 4096; a++) if (mem[a] !== img(a / 512, a % 512)) bad++;
    check("R4 image contents", 32'(bad), 0);
    check("R7 no timeout", 32'(boot_timeout), 0);
    check("R10 io_oe idle after copy", 32'(nand_io_oe), 0);
    walk_decode(1'b1);

    // Strap off: skip copy
    do_reset(1'b0, 30, 16'd1000);
    repeat (2) @(negedge clk);
    check("R6 cpu_rst_n quick release", 32'(cpu_rst_n), 1);
    check("R6 boot_done", 32'(boot_done), 1);
    walk_decode(1'b0);
    boot_nand = 1'b1;
    repeat (50) @(negedge clk);
    check("R6 no nand strobes", 32'(strobe_cnt + re_cnt), 0);
    check("R6 no sram writes", 32'(wr_cnt), 0);
    cpu_addr = 32'h0;
    #1;
    check("R11 late strap ignored bank0_n", 32'(cpu_sel_bank0_n), 0);
    check("R11 late strap ignored sram", 32'(cpu_sel_sram), 0);

    // Timeout: busy longer than the limit
    do_reset(1'b1, 100, 16'd20);
    repeat (300) @(negedge clk);
    check("R7 boot_timeout", 32'(boot_timeout), 1);
    check("R7 cpu held", 32'(cpu_rst_n), 0);
    check("R7 done low", 32'(boot_done), 0);
    check("R7 no read strobes", 32'(re_cnt), 0);
    check("R7 strobes stop after first page command", 32'(strobe_cnt), 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule